// File: doc/BRIEF.md
# Masked Latching Interrupt Controller

This block collects single-cycle event pulses from fourteen peripheral sources and holds them in a sticky flag register until software acknowledges them. A pulse is captured only when a global on/off register is on, the source's own bit in a mask register is set, and the processor is not holding its interrupt-inhibit input high. One summary output tells the processor that at least one captured event is waiting while the global register is on.

Software reaches three registers through a simple register port: a global on/off register, a 14-bit source mask and the flag register. The flag register is cleared by writing ones to the bits to be acknowledged. The processor's exception entry, any priority choice between sources and any vector generation are handled elsewhere.

Top module: `irqc_top`

## Requirements
- R1: After reset the global register, the mask register and the flag register all read 0, and `irq_pending_o` is low.
- R2: A write to address 0 turns the global register on for any nonzero data and off for zero data; reading address 0 returns 1 when on and 0 when off.
- R3: A write to address 1 stores data bits 13..0 into the mask register; reading address 1 returns the mask with bits 15 and 14 read as zero.
- R4: A request pulse on source i in a cycle where the global register is on, mask bit i is set and `cpu_irq_off_i` is low sets flag bit i, visible in the read of address 2 from the next cycle.
- R5: A request on a source whose mask bit is clear, or any request while the global register is off, leaves the flag register unchanged.
- R6: Requests made while `cpu_irq_off_i` is high leave the flag register unchanged.
- R7: A write to address 2 clears every flag bit whose data bit is 1, keeps every bit whose data bit is 0, and bits 15 and 14 always read as zero.
- R8: When a captured request and a clearing write hit the same flag bit in the same cycle, the flag bit ends up set.
- R9: `irq_pending_o` is high exactly when the global register is on and at least one flag bit is set; flags kept while the global register is off do not raise it.
- R10: Source i drives flag and mask bit i: 0 vertical blank, 1 horizontal blank, 2 line-counter match, 3 to 6 timer 0 to 3 overflow, 7 serial, 8 to 11 DMA channel 0 to 3, 12 keypad, 13 cartridge; reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req_i | input | 14 | One-cycle request pulses, bit i from source i |
| cpu_irq_off_i | input | 1 | Processor interrupt inhibit; high blocks capture |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 global, 1 mask, 2 flags, 3 unused |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register, combinational |
| irq_pending_o | output | 1 | Summary request to the processor |

## Verification
Each source is swept with a one-hot mask against an all-ones request vector and against its own one-hot request, which separates a wrong bit mapping from a missing mask gate. All-ones requests are then repeated with the global register off, with an empty mask and with the inhibit input high, so each of the three capture gates is shown to act on its own. Alternating clearing patterns over a full flag register distinguish clear-by-one from plain overwrite, and a request coinciding with its own clear tells the request-wins ordering from the opposite one. Toggling the global register while flags are held separates the pending output from the flag contents.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQC_SRC_N  = 14;
  localparam int IRQC_DW     = 16;
  localparam int IRQC_ADDR_W = 2;

  typedef enum logic [IRQC_ADDR_W-1:0] {
    SEL_GLOBAL = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_FLAGS  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int SRC_N = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] req,
  input  logic [SRC_N-1:0] mask,
  input  logic             gate,
  input  logic             clr_stb,
  input  logic [SRC_N-1:0] clr_bits,
  output logic [SRC_N-1:0] flags
);
  for (genvar g = 0; g < SRC_N; g++) begin : g_bit
    logic set_c;
    logic clr_c;
    logic flag_d;
    logic flag_q;
    logic flag_en;

    always_comb begin
      set_c   = req[g] & mask[g] & gate;
      clr_c   = clr_stb & clr_bits[g];
      flag_en = set_c | clr_c;
      // a new capture takes precedence over an acknowledge
      flag_d  = set_c | (flag_q & ~clr_c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_d;
    end

    assign flags[g] = flag_q;
  end
endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
  import irqc_pkg::*;
#(
  parameter int SRC_N = IRQC_SRC_N,
  parameter int DW    = IRQC_DW
) (
  input  logic [IRQC_ADDR_W-1:0] sel,
  input  logic                   global_on,
  input  logic [SRC_N-1:0]       mask,
  input  logic [SRC_N-1:0]       flags,
  output logic [DW-1:0]          rdata
);
  localparam int PAD_W = DW - SRC_N;

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_GLOBAL: rdata = {{(DW-1){1'b0}}, global_on};
      SEL_MASK:   rdata = {{PAD_W{1'b0}}, mask};
      SEL_FLAGS:  rdata = {{PAD_W{1'b0}}, flags};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int SRC_N = IRQC_SRC_N,
  parameter int DW    = IRQC_DW
) (
  input  logic                   clk,
  input  logic                   arst_n,
  input  logic [SRC_N-1:0]       src_req_i,
  input  logic                   cpu_irq_off_i,
  input  logic                   reg_wr_i,
  input  logic [IRQC_ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]          reg_wdata_i,
  output logic [DW-1:0]          reg_rdata_o,
  output logic                   irq_pending_o
);
  logic             rst_sync_n;
  logic             global_q;
  logic             global_d;
  logic             global_en;
  logic [SRC_N-1:0] mask_q;
  logic [SRC_N-1:0] mask_d;
  logic             mask_en;
  logic [SRC_N-1:0] flag_q;
  logic             capture_gate;
  logic             flag_clr_stb;

  irqc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    global_en    = reg_wr_i && (reg_addr_i == SEL_GLOBAL);
    global_d     = |reg_wdata_i;
    mask_en      = reg_wr_i && (reg_addr_i == SEL_MASK);
    mask_d       = reg_wdata_i[SRC_N-1:0];
    flag_clr_stb = reg_wr_i && (reg_addr_i == SEL_FLAGS);
    capture_gate = global_q & ~cpu_irq_off_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    global_q <= 1'b0;
    else if (global_en) global_q <= global_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  irqc_flag_bank #(.SRC_N(SRC_N)) u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req      (src_req_i),
    .mask     (mask_q),
    .gate     (capture_gate),
    .clr_stb  (flag_clr_stb),
    .clr_bits (reg_wdata_i[SRC_N-1:0]),
    .flags    (flag_q)
  );

  irqc_read_mux #(.SRC_N(SRC_N), .DW(DW)) u_rd (
    .sel       (reg_addr_i),
    .global_on (global_q),
    .mask      (mask_q),
    .flags     (flag_q),
    .rdata     (reg_rdata_o)
  );

  assign irq_pending_o = global_q & (|flag_q);
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int SRC_N = IRQC_SRC_N,
  parameter int DW    = IRQC_DW
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [SRC_N-1:0]       req,
  input logic                   cpu_off,
  input logic                   wr,
  input logic [IRQC_ADDR_W-1:0] addr,
  input logic [DW-1:0]          wdata,
  input logic [DW-1:0]          rdata,
  input logic                   global_q,
  input logic [SRC_N-1:0]       mask_q,
  input logic [SRC_N-1:0]       flag_q,
  input logic                   pending
);
  logic [SRC_N-1:0] grant;
  assign grant = req & mask_q & {SRC_N{global_q & ~cpu_off}};

  // R1
  reset_pending_low_chk: assert property (@(posedge clk) !rst_n |-> !pending);

  // R2
  global_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == SEL_GLOBAL && wdata != '0) |=> global_q);

  // R2
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == SEL_GLOBAL && wdata == '0) |=> !global_q);

  // R3
  mask_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == SEL_MASK) |-> (rdata[DW-1:SRC_N] == '0));

  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(grant)) == $past(grant)));

  // R5
  no_stray_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(grant)) == '0));

  // R6
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_off |=> ((flag_q & ~$past(flag_q)) == '0));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == SEL_FLAGS) |=> ((flag_q & $past(wdata[SRC_N-1:0]) & ~$past(grant)) == '0));

  // R9
  pending_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (global_q && flag_q != '0));

  // R9
  pending_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (global_q && flag_q != '0) |-> pending);
endmodule

bind irqc_top irqc_chk #(.SRC_N(SRC_N), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .req      (src_req_i),
  .cpu_off  (cpu_irq_off_i),
  .wr       (reg_wr_i),
  .addr     (reg_addr_i),
  .wdata    (reg_wdata_i),
  .rdata    (reg_rdata_o),
  .global_q (global_q),
  .mask_q   (mask_q),
  .flag_q   (flag_q),
  .pending  (irq_pending_o)
);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
  localparam int N = 14;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic        off = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pending;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic         m_glob = 1'b0;
  logic [N-1:0] m_mask = '0;
  logic [N-1:0] m_flag = '0;

  always #10 clk = ~clk;

  irqc_top uut (
    .clk (clk), .arst_n (arst_n), .src_req_i (req), .cpu_irq_off_i (off),
    .reg_wr_i (wr), .reg_addr_i (addr), .reg_wdata_i (wdata),
    .reg_rdata_o (rdata), .irq_pending_o (pending)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock with the given stimulus; model updated from pre-edge state
  task automatic cycle(input logic [N-1:0] r, input logic o, input logic w,
                       input logic [1:0] a, input logic [15:0] d);
    logic [N-1:0] set_v;
    logic [N-1:0] clr_v;
    @(negedge clk);
    req = r; off = o; wr = w; addr = a; wdata = d;
    @(posedge clk);
    set_v = r & m_mask & {N{m_glob & ~o}};
    clr_v = (w && a == 2'd2) ? d[N-1:0] : '0;
    m_flag = (m_flag & ~clr_v) | set_v;
    if (w && a == 2'd0) m_glob = (d != 16'h0);
    if (w && a == 2'd1) m_mask = d[N-1:0];
    @(negedge clk);
    req = '0; off = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic read_all(input string tag);
    addr = 2'd0; #1 check({tag, " global"}, rdata, {15'd0, m_glob});
    addr = 2'd1; #1 check({tag, " mask"},   rdata, {2'b00, m_mask});
    addr = 2'd2; #1 check({tag, " flags"},  rdata, {2'b00, m_flag});
    addr = 2'd3; #1 check({tag, " R10 unused"}, rdata, 16'h0);
    check({tag, " R9 pending"}, {15'd0, pending}, {15'd0, m_glob & (|m_flag)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_all("R1 reset");

    // R2: nonzero data turns global on, zero turns it off
    cycle('0, 1'b0, 1'b1, 2'd0, 16'h8000); read_all("R2 w8000");
    cycle('0, 1'b0, 1'b1, 2'd0, 16'h0000); read_all("R2 w0000");
    cycle('0, 1'b0, 1'b1, 2'd0, 16'h0042); read_all("R2 w0042");
    cycle('0, 1'b0, 1'b1, 2'd0, 16'h0001); read_all("R2 w0001");

    // R3: upper mask bits dropped
    cycle('0, 1'b0, 1'b1, 2'd1, 16'hFFFF); read_all("R3 ffff");
    cycle('0, 1'b0, 1'b1, 2'd1, 16'hA5A5); read_all("R3 a5a5");

    // R4 / R10: per-source sweep, one-hot mask vs all requests, and one-hot request
    for (int i = 0; i < N; i++) begin
      cycle('0, 1'b0, 1'b1, 2'd1, 16'(1 << i));
      cycle({N{1'b1}}, 1'b0, 1'b0, 2'd0, 16'h0);
      addr = 2'd2; #1 check($sformatf("R4 R10 src%0d onehot mask", i), rdata, 16'(1 << i));
      cycle('0, 1'b0, 1'b1, 2'd2, 16'hFFFF);
      cycle('0, 1'b0, 1'b1, 2'd1, 16'h3FFF);
      cycle(N'(1 << i), 1'b0, 1'b0, 2'd0, 16'h0);
      read_all($sformatf("R4 R10 src%0d onehot req", i));
      cycle('0, 1'b0, 1'b1, 2'd2, 16'hFFFF);
    end

    // R5: global off blocks capture
    cycle('0, 1'b0, 1'b1, 2'd0, 16'h0);
    cycle({N{1'b1}}, 1'b0, 1'b0, 2'd0, 16'h0); read_all("R5 global off");
    // R5: empty mask blocks capture
    cycle('0, 1'b0, 1'b1, 2'd0, 16'h1);
    cycle('0, 1'b0, 1'b1, 2'd1, 16'h0);
    cycle({N{1'b1}}, 1'b0, 1'b0, 2'd0, 16'h0); read_all("R5 mask empty");
    // R5: partial mask
    cycle('0, 1'b0, 1'b1, 2'd1, 16'h0F0F);
    cycle({N{1'b1}}, 1'b0, 1'b0, 2'd0, 16'h0); read_all("R5 partial mask");
    cycle('0, 1'b0, 1'b1, 2'd2, 16'hFFFF);

    // R6: inhibit blocks capture
    cycle('0, 1'b0, 1'b1, 2'd1, 16'h3FFF);
    cycle({N{1'b1}}, 1'b1, 1'b0, 2'd0, 16'h0); read_all("R6 inhibit");
    addr = 2'd2; #1 check("R6 flags held clear", rdata, 16'h0);

    // R7: alternating clears
    cycle({N{1'b1}}, 1'b0, 1'b0, 2'd0, 16'h0); read_all("R7 all set");
    cycle('0, 1'b0, 1'b1, 2'd2, 16'h5555); read_all("R7 clr 5555");
    addr = 2'd2; #1 check("R7 after 5555", rdata, 16'h2AAA);
    cycle('0, 1'b0, 1'b1, 2'd2, 16'hC000); read_all("R7 clr upper only");
    cycle('0, 1'b0, 1'b1, 2'd2, 16'h0AAA); read_all("R7 clr 0aaa");
    addr = 2'd2; #1 check("R7 after 0aaa", rdata, 16'h2000);

    // R8: request and clear on same bit
    cycle('0, 1'b0, 1'b1, 2'd2, 16'hFFFF);
    cycle(N'(1 << 3), 1'b0, 1'b0, 2'd0, 16'h0);
    cycle(N'(1 << 3), 1'b0, 1'b1, 2'd2, 16'h0008); read_all("R8 collide");
    addr = 2'd2; #1 check("R8 bit3 stays", rdata, 16'h0008);

    // R9: flags held with global off, pending low; back on, pending high
    cycle('0, 1'b0, 1'b1, 2'd0, 16'h0); read_all("R9 global off");
    check("R9 pending off", {15'd0, pending}, 16'h0);
    cycle('0, 1'b0, 1'b1, 2'd0, 16'h0100); read_all("R9 global on");
    check("R9 pending on", {15'd0, pending}, 16'h1);
    cycle('0, 1'b0, 1'b1, 2'd2, 16'hFFFF); read_all("R9 drained");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule